// File: doc/BRIEF.md
# Instruction Fetch-Execute Step Sequencer

This block is the control unit and datapath of a very small accumulator machine. It runs each instruction as four timing phases in a fixed order. A step counter keeps exactly one of four phase lines active. Each phase lasts two clocks. On the first clock the phase performs its register transfer. On the second clock it may issue a memory read strobe, so the address register is stable before the read. When the last phase ends, the counter returns to the first phase.

The first two phases fetch the instruction. The program counter moves into the memory address register, the word that is read moves into the instruction register, and the program counter then steps forward. In the last two phases the opcode held in the instruction register decides what happens. A load instruction sends its address field to the memory address register, reads that word, and places it in the accumulator. Every other opcode leaves the machine idle until the next fetch.

The instruction memory sits inside the block and reads synchronously. It has a write port so the test environment can preload it. While the hold input is high, the sequencer and all of its registers stay frozen, but the memory can still be written.

Top module: `fetch_step_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, address register, data register, instruction register and accumulator to zero, selects phase t1 (phase_o = 4'b0001) and selects its first clock (half_o = 0).
- R2: phase_o always has exactly one bit set, with bit 0 = t1 through bit 3 = t4. Each phase lasts two unheld clocks, and after t4 the sequence goes back to t1.
- R3: On the first clock of t1 the address register takes the program counter value. On the second clock rd_strobe_o is high, and the data register then holds the memory word at that address.
- R4: On the first clock of t2 the instruction register takes the data register. At the end of the second clock of t2 the program counter increments by one.
- R5: The instruction word is 12 bits, with the opcode in bits 11:8 and the address in bits 7:0. When the opcode is 4'h1 (load), the first clock of t3 copies bits 7:0 into the address register, and on the second clock of t3 rd_strobe_o is high and the data register is loaded from that address.
- R6: For the load opcode, the first clock of t4 copies the data register into the accumulator.
- R7: For any opcode other than 4'h1, rd_strobe_o stays low in t3 and t4, and the address register, data register and accumulator keep their values.
- R8: While hold is high, the phase, the half-step and every register keep their values. Memory writes through the write port still take effect.
- R9: The program counter wraps from 8'hFF to 8'h00 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes the sequencer and its registers |
| wr_en | input | 1 | Memory preload write enable |
| wr_addr | input | 8 | Memory preload address |
| wr_data | input | 12 | Memory preload data |
| phase_o | output | 4 | One-hot phase lines t1..t4 |
| half_o | output | 1 | 0 on the first clock of a phase, 1 on the second |
| rd_strobe_o | output | 1 | Memory read strobe |
| pc_o | output | 8 | Program counter |
| mar_o | output | 8 | Memory address register |
| mdr_o | output | 12 | Memory data register |
| ir_o | output | 12 | Instruction register |
| acc_o | output | 12 | Accumulator |

## Verification
The assertions check on every cycle that the phase is one-hot and rotates, that hold freezes the registers, and the transfers each phase makes: PC into MAR, the PC increment, the address field into MAR, and MDR into the accumulator. They also check that no read strobe occurs in the execute phases of an opcode other than load. Only the bench scenarios can show that the memory actually returns the preloaded word, that a short program of mixed opcodes leaves the expected accumulator values, and that the program counter wraps after 256 instructions.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {PH_T1 = 2'd0, PH_T2 = 2'd1, PH_T3 = 2'd2, PH_T4 = 2'd3} phase_e;
  localparam int NUM_PHASES = 4;
endpackage

// File: rtl/fss_step_counter.sv
// Two-clock-per-phase step counter; wraps to t1 after the last phase.
module fss_step_counter
  import fss_pkg::*;
#(
  parameter int PHASES = NUM_PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  output logic [PHASES-1:0] phase_oh,
  output logic              half
);
  phase_e idx_q;
  logic   half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= PH_T1;
      half_q <= 1'b0;
    end else if (adv_en) begin
      half_q <= ~half_q;
      if (half_q) begin
        if (idx_q == PH_T4) idx_q <= PH_T1;
        else                idx_q <= phase_e'(idx_q + 2'd1);
      end
    end
  end

  for (genvar k = 0; k < PHASES; k++) begin : g_line
    assign phase_oh[k] = (idx_q == phase_e'(k));
  end

  assign half = half_q;
endmodule

// File: rtl/fss_step_decoder.sv
// Combines phase lines, half-step and opcode into register-transfer switches.
module fss_step_decoder #(
  parameter int               OPC_W    = 4,
  parameter logic [OPC_W-1:0] LOAD_OPC = 4'h1
) (
  input  logic [3:0]       phase_oh,
  input  logic             half,
  input  logic [OPC_W-1:0] opcode,
  output logic             mar_from_pc,
  output logic             ir_from_mdr,
  output logic             pc_inc,
  output logic             mar_from_ir,
  output logic             acc_from_mdr,
  output logic             rd_req
);
  logic is_load;
  assign is_load = (opcode == LOAD_OPC);

  always_comb begin
    mar_from_pc  = phase_oh[0] & ~half;
    ir_from_mdr  = phase_oh[1] & ~half;
    pc_inc       = phase_oh[1] &  half;
    mar_from_ir  = phase_oh[2] & ~half & is_load;
    acc_from_mdr = phase_oh[3] & ~half & is_load;
    rd_req       = half & (phase_oh[0] | (phase_oh[2] & is_load));
  end
endmodule

// File: rtl/fss_word_mem.sv
// Single-clock memory with registered read output (the data register).
module fss_word_mem #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= store[rd_addr];
  end
endmodule

// File: rtl/fetch_step_seq.sv
module fetch_step_seq #(
  parameter int               ADDR_W   = 8,
  parameter int               OPC_W    = 4,
  parameter logic [OPC_W-1:0] LOAD_OPC = 4'h1,
  localparam int              WORD_W   = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [3:0]        phase_o,
  output logic              half_o,
  output logic              rd_strobe_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mdr_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [WORD_W-1:0] acc_o
);
  logic run;
  logic mar_from_pc, ir_from_mdr, pc_inc, mar_from_ir, acc_from_mdr, rd_req;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] ir_q, acc_q, mdr;

  assign run = ~hold;

  fss_step_counter #(.PHASES(4)) u_cnt (
    .clk(clk), .rst(rst), .adv_en(run), .phase_oh(phase_o), .half(half_o)
  );

  fss_step_decoder #(.OPC_W(OPC_W), .LOAD_OPC(LOAD_OPC)) u_dec (
    .phase_oh(phase_o), .half(half_o), .opcode(ir_q[WORD_W-1:ADDR_W]),
    .mar_from_pc(mar_from_pc), .ir_from_mdr(ir_from_mdr), .pc_inc(pc_inc),
    .mar_from_ir(mar_from_ir), .acc_from_mdr(acc_from_mdr), .rd_req(rd_req)
  );

  fss_word_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(run & rd_req), .rd_addr(mar_q), .rd_q(mdr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else if (run) begin
      if (mar_from_pc)  mar_q <= pc_q;
      if (mar_from_ir)  mar_q <= ir_q[ADDR_W-1:0];
      if (ir_from_mdr)  ir_q  <= mdr;
      if (pc_inc)       pc_q  <= pc_q + 1'b1;
      if (acc_from_mdr) acc_q <= mdr;
    end
  end

  assign rd_strobe_o = rd_req;
  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr;
  assign ir_o  = ir_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int               ADDR_W   = 8,
  parameter int               OPC_W    = 4,
  parameter logic [OPC_W-1:0] LOAD_OPC = 4'h1,
  localparam int              WORD_W   = OPC_W + ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic [3:0]        phase_o,
  input logic              half_o,
  input logic              rd_strobe_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] mar_o,
  input logic [WORD_W-1:0] mdr_o,
  input logic [WORD_W-1:0] ir_o,
  input logic [WORD_W-1:0] acc_o
);
  logic is_load;
  assign is_load = (ir_o[WORD_W-1:ADDR_W] == LOAD_OPC);

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);

  a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
    (!hold && half_o) |=> (phase_o == {$past(phase_o[2:0]), $past(phase_o[3])}));

  a_r3_mar_pc: assert property (@(posedge clk) disable iff (rst)
    (!hold && phase_o[0] && !half_o) |=> (mar_o == $past(pc_o)));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!hold && phase_o[1] && half_o) |=> (pc_o == $past(pc_o) + 1'b1));

  a_r5_mar_addr: assert property (@(posedge clk) disable iff (rst)
    (!hold && phase_o[2] && !half_o && is_load) |=> (mar_o == $past(ir_o[ADDR_W-1:0])));

  a_r6_acc_load: assert property (@(posedge clk) disable iff (rst)
    (!hold && phase_o[3] && !half_o && is_load) |=> (acc_o == $past(mdr_o)));

  a_r7_no_read: assert property (@(posedge clk) disable iff (rst)
    ((phase_o[2] || phase_o[3]) && !is_load) |-> !rd_strobe_o);

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(phase_o) && $stable(half_o) && $stable(pc_o) && $stable(mar_o)
              && $stable(mdr_o) && $stable(ir_o) && $stable(acc_o)));
endmodule

bind fetch_step_seq fss_checker #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .LOAD_OPC(LOAD_OPC)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .phase_o(phase_o), .half_o(half_o),
  .rd_strobe_o(rd_strobe_o), .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o),
  .ir_o(ir_o), .acc_o(acc_o)
);

// File: tb/sim_fetch_step_seq.sv
module sim_fetch_step_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {instruction, data at its address, expected accumulator afterwards}
  localparam logic [35:0] VEC [NV] = '{
    {12'h120, 12'hABC, 12'hABC},
    {12'h221, 12'h5A5, 12'hABC},
    {12'h121, 12'h5A5, 12'h5A5},
    {12'hFFF, 12'h000, 12'h5A5},
    {12'h1FF, 12'h001, 12'h001},
    {12'h000, 12'h000, 12'h001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1, hold = 1'b1, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  phase_o;
  logic        half_o, rd_strobe_o;
  logic [7:0]  pc_o, mar_o;
  logic [11:0] mdr_o, ir_o, acc_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_step_seq u0 (
    .clk(clk), .rst(rst), .hold(hold), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_o(phase_o), .half_o(half_o), .rd_strobe_o(rd_strobe_o), .pc_o(pc_o),
    .mar_o(mar_o), .mdr_o(mdr_o), .ir_o(ir_o), .acc_o(acc_o)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mem_write(input logic [7:0] a, input logic [11:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    // R1: reset state
    check("R1 phase", phase_o, 4'b0001);
    check("R1 half", half_o, 0);
    check("R1 pc", pc_o, 0);
    check("R1 mar", mar_o, 0);
    check("R1 mdr", mdr_o, 0);
    check("R1 ir", ir_o, 0);
    check("R1 acc", acc_o, 0);
    rst = 1'b0;
    // preload while held (R8: writes land during hold)
    for (int a = 0; a < 256; a++) mem_write(8'(a), 12'h300);
    for (int i = 0; i < NV; i++) begin
      mem_write(8'(i), VEC[i][35:24]);
      if (VEC[i][35:32] == 4'h1) mem_write(VEC[i][31:24], VEC[i][23:12]);
    end
    check("R8 pc held", pc_o, 0);
    check("R8 phase held", phase_o, 4'b0001);
    hold = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] ins, dat, accx, prev_acc;
      logic [7:0] pcb;
      logic ld;
      ins = VEC[i][35:24]; dat = VEC[i][23:12]; accx = VEC[i][11:0];
      ld = (ins[11:8] == 4'h1);
      pcb = pc_o; prev_acc = acc_o;
      check("R2 t1 start", phase_o, 4'b0001);
      tick();
      check("R3 mar<=pc", mar_o, pcb);
      check("R3 strobe t1", rd_strobe_o, 1);
      check("R2 half", half_o, 1);
      tick();
      check("R3 mdr word", mdr_o, ins);
      check("R2 t2", phase_o, 4'b0010);
      tick();
      check("R4 ir", ir_o, ins);
      tick();
      check("R4 pc+1", pc_o, 8'(pcb + 1));
      check("R2 t3", phase_o, 4'b0100);
      tick();
      if (ld) check("R5 mar addr", mar_o, ins[7:0]);
      else    check("R7 mar kept", mar_o, pcb);
      check(ld ? "R5 strobe" : "R7 no strobe", rd_strobe_o, ld);
      tick();
      if (ld) check("R5 mdr data", mdr_o, dat);
      else    check("R7 mdr kept", mdr_o, ins);
      check("R2 t4", phase_o, 4'b1000);
      check(ld ? "R6 strobe off t4" : "R7 no strobe t4", rd_strobe_o, 0);
      tick();
      if (ld) check("R6 acc", acc_o, accx);
      else    check("R7 acc kept", acc_o, prev_acc);
      tick();
      check("R2 back to t1", phase_o, 4'b0001);
    end

    // R8: hold mid-phase
    tick();
    hold = 1'b1;
    repeat (3) tick();
    check("R8 phase frozen", phase_o, 4'b0001);
    check("R8 half frozen", half_o, 1);
    check("R8 mdr frozen", mdr_o, 12'h000);
    check("R8 pc frozen", pc_o, 6);
    hold = 1'b0;
    tick();
    check("R8 resume read", mdr_o, 12'h300);

    // R9: program counter wrap
    rst = 1'b1; hold = 1'b1;
    tick();
    mem_write(8'hFF, 12'h130);
    mem_write(8'h30, 12'h777);
    rst = 1'b0; hold = 1'b0;
    repeat (255 * 8) tick();
    check("R9 pc at top", pc_o, 8'hFF);
    check("R9 phase t1", phase_o, 4'b0001);
    repeat (8) tick();
    check("R9 pc wrapped", pc_o, 0);
    check("R9 load at top", acc_o, 12'h777);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule